// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block conditions a bank of shared interrupt inputs for a global interrupt controller. Each input first goes through a synchronizer. Per-source configuration then decides how the input becomes a pending request. The configuration covers three choices:

- active polarity;
- level or edge sensing;
- for edge sources, whether one edge or both edges count.

A pending request that is unmasked and routed to an output pin drives that pin. A request routed to the non-maskable output drives that output whatever its mask bit holds.

Software reaches the block through a 32-bit register port. The word address is `{region[3:0], index}`, where `index` is log2(NUM_SRC) bits wide.

- Polarity, sense and dual-edge settings are bit-per-source words, with source `s` in word `s/32`, bit `s%32`.
- The mask has separate write-one-to-clear and write-one-to-set ports, plus a read-only view.
- Pending state is read through a read-only bit-per-source view.
- A trigger word sets or clears one source's edge latch by number.
- Each source has a routing word that selects a pin, or the non-maskable output.

Reads are combinational from the address. A write takes effect on the clock edge where `reg_wr` is high.

Top module: `shared_irq_cond`

## Requirements
- R1: After reset the mask, all edge latches and all routing words are zero, and `pin_irq` and `nmi_irq` are low. The polarity words reset to all ones (region 0), so idle-low inputs read as not pending in the pending view (region 6).
- R2: For a level source (sense bit 0, region 1), the pending bit follows the synchronized input. It is active-high when the polarity bit (region 0) is 1 and active-low when that bit is 0.
- R3: For an edge source (sense bit 1) with dual bit 0 (region 2), polarity 1 latches pending on a rising edge and polarity 0 on a falling edge. The opposite edge does nothing, and the latch stays set after the input returns.
- R4: For an edge source with dual bit 1, both rising and falling edges latch pending whatever the polarity; an input that does not change latches nothing.
- R5: A write to the trigger word (region 7) takes a source number in bits 7:0. Bit 31 = 1 sets that source's edge latch and bit 31 = 0 clears it. A number at or above NUM_SRC changes nothing.
- R6: In the clear port (region 3) and the set port (region 4), a 1 bit clears or sets the mask bit and a 0 bit has no effect. The current mask reads from region 5.
- R7: `pin_irq[p]` is high one cycle after some source is pending, has its mask bit set, and has a routing word with bit 31 = 1, bit 30 = 0 and bits 5:0 = p. Clearing the mask bit removes it.
- R8: `nmi_irq` is high one cycle after any pending source has routing bit 30 = 1, regardless of its mask. Such a source never drives a pin, even with bit 31 set.
- R9: A routing word (region 8, index = source) stores only bits 31, 30 and 5:0, and reads back with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Raw asynchronous interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4+log2(NUM_SRC) | Word address {region, index} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pin_irq | output | NUM_PIN | Conditioned interrupt pins |
| nmi_irq | output | 1 | Non-maskable interrupt output |

## Verification
A table drives one source through every combination of the three sensing controls, each time with an input transition whose result tells the modes apart:

- a rising step, which separates active-high level sensing from active-low level sensing;
- the edge direction against single-edge polarity, where the wrong edge must stay quiet;
- falling steps and held levels under dual-edge mode, which show that both edges count and that a still input does not.

Directed patterns then exercise routing to a high pin number against masking, and NMI routing with the mask cleared and with the pin-enable bit also set. They also cover a trigger word aimed past the last source and writes of zero bits to the mask ports.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
   localparam int WORD_W      = 32;
   localparam int REGION_W    = 4;
   localparam int PIN_FIELD_W = 6;
   localparam int TRIG_SEL_W  = 8;
   localparam int TRIG_ARM    = 31;
   localparam int ROUTE_PIN   = 31;
   localparam int ROUTE_NMI   = 30;

   typedef enum logic [REGION_W-1:0] {
      RG_POL   = 4'd0,
      RG_SENSE = 4'd1,
      RG_DUAL  = 4'd2,
      RG_MCLR  = 4'd3,
      RG_MSET  = 4'd4,
      RG_MASK  = 4'd5,
      RG_PEND  = 4'd6,
      RG_TRIG  = 4'd7,
      RG_ROUTE = 4'd8
   } region_e;

   typedef struct packed {
      logic                   to_pin;
      logic                   to_nmi;
      logic [PIN_FIELD_W-1:0] pin;
   } route_t;

   function automatic logic [WORD_W-1:0] pack_route(route_t r);
      logic [WORD_W-1:0] w;
      w = '0;
      w[ROUTE_PIN] = r.to_pin;
      w[ROUTE_NMI] = r.to_nmi;
      w[PIN_FIELD_W-1:0] = r.pin;
      return w;
   endfunction
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_sync_bank: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic pol,
   input  logic edge_mode,
   input  logic dual,
   input  logic sw_set,
   input  logic sw_clr,
   output logic pend,
   output logic latched
);
   logic prev_q;
   logic lat_q;
   logic rise, fall, hit;

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
   assign hit  = dual ? (rise | fall) : (pol ? rise : fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (edge_mode && hit) lat_q <= 1'b1;
         else if (sw_clr)      lat_q <= 1'b0;
         else if (sw_set)      lat_q <= 1'b1;
      end
   end

   assign pend    = edge_mode ? lat_q : (pol ? lvl : ~lvl);
   assign latched = lat_q;
endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge
   import irq_cond_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int NUM_PIN = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   pend,
   input  logic [NUM_SRC-1:0]   mask,
   input  route_t [NUM_SRC-1:0] routes,
   output logic [NUM_PIN-1:0]   pin_irq,
   output logic                 nmi_irq
);
   logic [NUM_SRC-1:0] eligible;
   logic [NUM_PIN-1:0] pin_hit;
   logic               nmi_hit;

   assign eligible = pend & mask;

   genvar p;
   generate
      for (p = 0; p < NUM_PIN; p++) begin : g_pin
         always_comb begin
            pin_hit[p] = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
               if (eligible[s] && routes[s].to_pin && !routes[s].to_nmi &&
                   routes[s].pin == PIN_FIELD_W'(p))
                  pin_hit[p] = 1'b1;
            end
         end
      end
   endgenerate

   always_comb begin
      nmi_hit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (pend[s] && routes[s].to_nmi) nmi_hit = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_irq <= '0;
         nmi_irq <= 1'b0;
      end else begin
         pin_irq <= pin_hit;
         nmi_irq <= nmi_hit;
      end
   end
endmodule

// File: rtl/shared_irq_cond.sv
module shared_irq_cond
   import irq_cond_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int NUM_PIN     = 64,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(NUM_SRC),
   localparam int ADDR_W     = REGION_W + IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic [NUM_PIN-1:0] pin_irq,
   output logic               nmi_irq
);
   localparam int NUM_WORDS = NUM_SRC / WORD_W;

   generate
      if (NUM_SRC % WORD_W != 0 || NUM_SRC < WORD_W || NUM_SRC > 256) begin : g_bad_src
         $error("shared_irq_cond: NUM_SRC must be a multiple of 32 in 32..256");
      end
      if (NUM_PIN < 1 || NUM_PIN > (1 << PIN_FIELD_W)) begin : g_bad_pin
         $error("shared_irq_cond: NUM_PIN must be in 1..64");
      end
   endgenerate

   region_e            region;
   logic [IDX_W-1:0]   idx;
   logic [NUM_SRC-1:0] pol_q, sense_q, dual_q, mask_q;
   route_t [NUM_SRC-1:0] route_q;
   logic [NUM_SRC-1:0] sync_q, pend_vec, lat_vec, sw_set_vec, sw_clr_vec;
   logic               trig_ok;
   logic [TRIG_SEL_W-1:0] trig_sel;
   logic               idx_is_src;

   assign region     = region_e'(reg_addr[ADDR_W-1 -: REGION_W]);
   assign idx        = reg_addr[IDX_W-1:0];
   assign idx_is_src = ({1'b0, idx} < (IDX_W+1)'(NUM_SRC));
   assign trig_sel   = reg_wdata[TRIG_SEL_W-1:0];
   assign trig_ok    = reg_wr && (region == RG_TRIG) &&
                       ({1'b0, trig_sel} < (TRIG_SEL_W+1)'(NUM_SRC));

   irq_sync_bank #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_in),
      .q     (sync_q)
   );

   // configuration and mask words, one 32-bit slice per word index
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q   <= '1;
         sense_q <= '0;
         dual_q  <= '0;
         mask_q  <= '0;
      end else if (reg_wr) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == IDX_W'(w)) begin
               case (region)
                  RG_POL:   pol_q[w*WORD_W +: WORD_W]   <= reg_wdata;
                  RG_SENSE: sense_q[w*WORD_W +: WORD_W] <= reg_wdata;
                  RG_DUAL:  dual_q[w*WORD_W +: WORD_W]  <= reg_wdata;
                  RG_MCLR:  mask_q[w*WORD_W +: WORD_W]  <= mask_q[w*WORD_W +: WORD_W] & ~reg_wdata;
                  RG_MSET:  mask_q[w*WORD_W +: WORD_W]  <= mask_q[w*WORD_W +: WORD_W] | reg_wdata;
                  default: ;
               endcase
            end
         end
      end
   end

   // routing words, one per source
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
      end else if (reg_wr && region == RG_ROUTE && idx_is_src) begin
         route_q[idx] <= route_t'{to_pin: reg_wdata[ROUTE_PIN],
                                  to_nmi: reg_wdata[ROUTE_NMI],
                                  pin:    reg_wdata[PIN_FIELD_W-1:0]};
      end
   end

   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_src
         assign sw_set_vec[s] = trig_ok && (trig_sel == TRIG_SEL_W'(s)) && reg_wdata[TRIG_ARM];
         assign sw_clr_vec[s] = trig_ok && (trig_sel == TRIG_SEL_W'(s)) && !reg_wdata[TRIG_ARM];

         irq_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (sync_q[s]),
            .pol       (pol_q[s]),
            .edge_mode (sense_q[s]),
            .dual      (dual_q[s]),
            .sw_set    (sw_set_vec[s]),
            .sw_clr    (sw_clr_vec[s]),
            .pend      (pend_vec[s]),
            .latched   (lat_vec[s])
         );
      end
   endgenerate

   irq_pin_merge #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend_vec),
      .mask    (mask_q),
      .routes  (route_q),
      .pin_irq (pin_irq),
      .nmi_irq (nmi_irq)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (region)
         RG_POL, RG_SENSE, RG_DUAL, RG_MASK, RG_PEND: begin
            for (int w = 0; w < NUM_WORDS; w++) begin
               if (idx == IDX_W'(w)) begin
                  case (region)
                     RG_POL:   reg_rdata = pol_q[w*WORD_W +: WORD_W];
                     RG_SENSE: reg_rdata = sense_q[w*WORD_W +: WORD_W];
                     RG_DUAL:  reg_rdata = dual_q[w*WORD_W +: WORD_W];
                     RG_MASK:  reg_rdata = mask_q[w*WORD_W +: WORD_W];
                     default:  reg_rdata = pend_vec[w*WORD_W +: WORD_W];
                  endcase
               end
            end
         end
         RG_ROUTE: if (idx_is_src) reg_rdata = pack_route(route_q[idx]);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_cond_checker.sv
module irq_cond_checker
   import irq_cond_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int NUM_PIN = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic [NUM_SRC-1:0]   pend,
   input logic [NUM_SRC-1:0]   mask,
   input logic [NUM_SRC-1:0]   lat,
   input route_t [NUM_SRC-1:0] routes,
   input logic [NUM_PIN-1:0]   pin_irq,
   input logic                 nmi_irq
);
   // R6: mask moves only on a register write
   assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(mask));

   // R3: a set edge latch is only cleared by software
   assert_latch_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ((lat & $past(lat)) == $past(lat)));

   // R7: a pin needs an unmasked pending source in the cycle before
   assert_pin_needs_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|pin_irq) |-> $past(|(pend & mask)));

   // R8: the NMI output needs a pending source in the cycle before
   assert_nmi_needs_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_irq |-> $past(|pend));

   // R9: routing words move only on a register write
   assert_route_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(routes));
endmodule

bind shared_irq_cond irq_cond_checker #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) u_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_wr  (reg_wr),
   .pend    (pend_vec),
   .mask    (mask_q),
   .lat     (lat_vec),
   .routes  (route_q),
   .pin_irq (pin_irq),
   .nmi_irq (nmi_irq)
);

// File: tb/shared_irq_cond_test.sv
`timescale 1ns/1ps
module shared_irq_cond_test;
   localparam int NSRC = 32;
   localparam int NPIN = 64;
   localparam int IW   = 5;
   localparam int AW   = 4 + IW;

   // region codes
   localparam logic [3:0] G_POL = 0, G_SENSE = 1, G_DUAL = 2, G_MCLR = 3, G_MSET = 4,
                          G_MASK = 5, G_PEND = 6, G_TRIG = 7, G_ROUTE = 8;

   // table fields: [5] pol [4] edge [3] dual [2] start level [1] end level [0] expected pending
   localparam logic [5:0] VEC [12] = '{
      6'b100011, 6'b100100, 6'b000101, 6'b000010,
      6'b110011, 6'b110100, 6'b010101, 6'b010010,
      6'b111011, 6'b111101, 6'b111110, 6'b011011
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_in = '0;
   logic            reg_wr = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NPIN-1:0] pin_irq;
   logic            nmi_irq;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   shared_irq_cond #(.NUM_SRC(NSRC), .NUM_PIN(NPIN)) uut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_irq(pin_irq), .nmi_irq(nmi_irq)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] rg, input int ix, input logic [31:0] d);
      reg_addr  = {rg, IW'(ix)};
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] rg, input int ix, output logic [31:0] d);
      reg_addr = {rg, IW'(ix)};
      #1;
      d = reg_rdata;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(3);

      // R1: reset state
      rd(G_PEND, 0, r);  check("R1 pending", 64'(r), 64'h0);
      rd(G_MASK, 0, r);  check("R1 mask", 64'(r), 64'h0);
      rd(G_ROUTE, 5, r); check("R1 route", 64'(r), 64'h0);
      rd(G_POL, 0, r);   check("R1 polarity", 64'(r), 64'hFFFF_FFFF);
      check("R1 pins", pin_irq, 64'h0);
      check("R1 nmi", 64'(nmi_irq), 64'h0);

      // R2 R3 R4: sensing table on source 3
      for (int i = 0; i < 12; i++) begin
         automatic logic [5:0] v = VEC[i];
         wr(G_POL, 0, v[5] ? 32'hFFFF_FFFF : 32'hFFFF_FFF7);
         wr(G_SENSE, 0, v[4] ? 32'h8 : 32'h0);
         wr(G_DUAL, 0, v[3] ? 32'h8 : 32'h0);
         src_in[3] = v[2];
         wait_cyc(6);
         wr(G_TRIG, 0, 32'h0000_0003);
         src_in[3] = v[1];
         wait_cyc(6);
         rd(G_PEND, 0, r);
         if (!v[4])      check($sformatf("R2 level row %0d", i), 64'(r[3]), 64'(v[0]));
         else if (!v[3]) check($sformatf("R3 edge row %0d", i), 64'(r[3]), 64'(v[0]));
         else            check($sformatf("R4 dual row %0d", i), 64'(r[3]), 64'(v[0]));
      end
      wr(G_POL, 0, 32'hFFFF_FFFF);
      wr(G_SENSE, 0, 32'h0);
      wr(G_DUAL, 0, 32'h0);
      src_in = '0;
      wait_cyc(6);

      // R6: write-one mask ports
      wr(G_MSET, 0, 32'h0000_00F0); rd(G_MASK, 0, r); check("R6 set", 64'(r), 64'hF0);
      wr(G_MCLR, 0, 32'h0000_0030); rd(G_MASK, 0, r); check("R6 clear", 64'(r), 64'hC0);
      wr(G_MSET, 0, 32'h0);         rd(G_MASK, 0, r); check("R6 set zeros", 64'(r), 64'hC0);
      wr(G_MCLR, 0, 32'h0);         rd(G_MASK, 0, r); check("R6 clear zeros", 64'(r), 64'hC0);

      // R5: trigger word on edge source 7
      wr(G_SENSE, 0, 32'h80);
      wr(G_TRIG, 0, 32'h8000_0007); rd(G_PEND, 0, r); check("R5 set", 64'(r), 64'h80);
      wr(G_TRIG, 0, 32'h8000_0028); rd(G_PEND, 0, r); check("R5 out of range", 64'(r), 64'h80);
      wr(G_TRIG, 0, 32'h0000_0007); rd(G_PEND, 0, r); check("R5 clear", 64'(r), 64'h0);

      // R3: latch holds after input returns
      src_in[7] = 1'b1; wait_cyc(6);
      rd(G_PEND, 0, r); check("R3 rising latched", 64'(r[7]), 64'h1);
      src_in[7] = 1'b0; wait_cyc(6);
      rd(G_PEND, 0, r); check("R3 sticky", 64'(r[7]), 64'h1);
      wr(G_TRIG, 0, 32'h0000_0007);
      wr(G_SENSE, 0, 32'h0);

      // R9: route word storage
      wr(G_ROUTE, 5, 32'hFFFF_FFFF);
      rd(G_ROUTE, 5, r); check("R9 readback", 64'(r), 64'hC000_003F);

      // R7: pin routing with mask
      wr(G_MSET, 0, 32'h200);
      wr(G_ROUTE, 9, 32'h8000_0025);
      src_in[9] = 1'b1; wait_cyc(6);
      check("R7 pin 37", pin_irq, 64'h1 << 37);
      check("R7 no nmi", 64'(nmi_irq), 64'h0);
      wr(G_MCLR, 0, 32'h200); wait_cyc(2);
      check("R7 masked", pin_irq, 64'h0);

      // R8: NMI routing ignores mask and wins over pin enable
      wr(G_ROUTE, 9, 32'h4000_0025); wait_cyc(2);
      check("R8 nmi masked", 64'(nmi_irq), 64'h1);
      check("R8 no pin", pin_irq, 64'h0);
      wr(G_MSET, 0, 32'h200);
      wr(G_ROUTE, 9, 32'hC000_0025); wait_cyc(2);
      check("R8 nmi over pin", 64'(nmi_irq), 64'h1);
      check("R8 pin suppressed", pin_irq, 64'h0);
      src_in[9] = 1'b0; wait_cyc(6);
      check("R8 nmi drops", 64'(nmi_irq), 64'h0);

      finish_run();
   end
endmodule